// File: doc/BRIEF.md
# Reset Boot Mode Sequencer

After every reset this block decides where the processor begins executing and keeps the processor held in reset until that decision is made. It reads a boot-select input. When boot-select is low, the boot comes from an external parallel flash or ROM. The block reads a 32-bit reset vector from that device over a simple request/ready read port. Bit 0 of the vector sets the bus width of the boot device. The jump address is the vector with bit 0 cleared.

When boot-select is high, a second pin is read as a strap. This pin is shared: in flash boot it is the chip select of the flash. For a strap read, the block first stops driving the pin and switches off its pull-up. It then waits a parameterised settle time so that the external resistor can set the level, and then samples the pin. A high strap selects serial EEPROM boot, with code placed in internal RAM at offset 0x100. A low strap selects serial host boot, which starts at a fixed internal address.

The controller has five named states. DECIDE is the reset state and reads boot-select. FETCH waits for the vector read engine. SETTLE waits on the settle timer. FINISH is the single cycle in which the done pulse is high. RUN is terminal until the next reset. The transitions are:
- DECIDE to FETCH when boot-select is low.
- DECIDE to SETTLE when boot-select is high.
- FETCH to FINISH when the vector is complete.
- SETTLE to FINISH when the timer expires.
- FINISH to RUN unconditionally.
- RUN to RUN for ever after.

Top module: `boot_seq_top`

## Requirements
- R1: With boot_sel_i = 0, boot_mode_o becomes 2'b00. The shared pin stays an output (strap_oe_o = 1) and its pull-up stays enabled (strap_pu_o = 1).
- R2: With boot_sel_i = 1, the shared pin is released (strap_oe_o = 0) and its pull-up is disabled (strap_pu_o = 0) from the first clock after reset onward. A strap level of 1 then gives boot_mode_o = 2'b01 and start_addr_o = 0x0000_0100.
- R3: With boot_sel_i = 1 and a strap level of 0, boot_mode_o = 2'b10 and start_addr_o = HOST_START (default 0x0000_0000).
- R4: The flash vector is fetched as two 16-bit reads, little-endian. The first read is at 0x2000_0000 and gives bits 15:0. The second is at 0x2000_0002 and gives bits 31:16. The request and address of each read hold steady until mem_rdy_i is sampled high.
- R5: dev_w8_o equals bit 0 of the fetched vector (1 = 8-bit device, 0 = 16-bit device). It is 0 in the two serial modes.
- R6: In flash boot, start_addr_o equals the fetched vector with bit 0 forced to 0.
- R7: The strap is sampled on the clock edge SETTLE_CYC cycles after the pull-up is switched off. done_o is high after the (SETTLE_CYC+1)-th rising edge after reset release.
- R8: done_o is high for exactly one cycle per reset. After that pulse, boot_mode_o, start_addr_o and dev_w8_o do not change until the next reset.
- R9: cpu_hold_o is 1 from reset until done_o rises, and it falls in the same cycle that done_o is high.
- R10: strap_do_o is the active-low flash chip select. It is 0 exactly while mem_req_o is 1, and 1 otherwise.
- R11: During reset the outputs are: cpu_hold_o = 1, done_o = 0, strap_pu_o = 1, strap_oe_o = 1, boot_mode_o = 2'b00, start_addr_o = 0, mem_req_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_sel_i | input | 1 | Boot-select pin: 0 selects flash boot, 1 selects a strap read |
| strap_pin_i | input | 1 | Level read from the shared pin |
| strap_do_o | output | 1 | Value driven onto the shared pin (active-low chip select) |
| strap_oe_o | output | 1 | Output enable for the shared pin |
| strap_pu_o | output | 1 | Pull-up enable for the shared pin |
| mem_req_o | output | 1 | External read request |
| mem_addr_o | output | 32 | External read byte address |
| mem_rdy_i | input | 1 | Read complete; mem_rdata_i is valid |
| mem_rdata_i | input | 16 | External read data |
| boot_mode_o | output | 2 | Boot mode: 00 flash, 01 serial EEPROM, 10 serial host |
| dev_w8_o | output | 1 | Boot device width: 1 = 8-bit, 0 = 16-bit |
| start_addr_o | output | 32 | Execution start address |
| done_o | output | 1 | One-cycle pulse when the decision is complete |
| cpu_hold_o | output | 1 | Holds the processor in reset while high |

## Verification
Some properties are checked by assertions on every cycle:
- The done pulse lasts one cycle, and the hold output falls only together with it.
- The results are frozen once the hold is released, and the mode code is never 11.
- The pin stays released with its pull-up off throughout the settle wait.
- The read request and address do not move while a read is waiting for ready.
- The settle counter steps down by one each cycle.

Other behaviour can only be shown by the bench scenarios. These cover:
- The address order and the little-endian assembly of the two halves.
- The width bit and the cleared jump bit for several vectors and ready latencies.
- Both strap levels, and the exact cycle on which the strap is sampled.
- The chip-select level seen on the shared pin.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    typedef enum logic [2:0] {
        ST_DECIDE,
        ST_FETCH,
        ST_SETTLE,
        ST_FINISH,
        ST_RUN
    } seq_state_e;

    typedef enum logic {
        FE_IDLE,
        FE_READ
    } fetch_state_e;

    localparam logic [1:0] MODE_FLASH  = 2'b00;
    localparam logic [1:0] MODE_EEPROM = 2'b01;
    localparam logic [1:0] MODE_HOST   = 2'b10;

endpackage

// File: rtl/boot_settle_timer.sv
module boot_settle_timer #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign expire_o = run_q && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(SETTLE_CYC - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R7: while waiting, the settle count steps down by exactly one per cycle
    assert_settle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != '0 && !start_i) |=> (run_q && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/boot_vec_fetch.sv
module boot_vec_fetch
    import bootseq_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter int              BUS_W    = 16,
    parameter int              VEC_W    = 32,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rdy_i,
    input  logic [BUS_W-1:0]  rdata_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              done_o
);
    localparam int NBEATS = VEC_W / BUS_W;
    localparam int BEAT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1;
    localparam int STEP   = BUS_W / 8;

    fetch_state_e      st_q;
    logic [BEAT_W-1:0] beat_q;
    logic [VEC_W-1:0]  vec_q;
    logic              done_q;

    assign req_o  = (st_q == FE_READ);
    assign addr_o = VEC_ADDR + ADDR_W'(beat_q) * ADDR_W'(STEP);
    assign vec_o  = vec_q;
    assign done_o = done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= FE_IDLE;
            beat_q <= '0;
            vec_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                FE_IDLE: begin
                    if (start_i) begin
                        st_q   <= FE_READ;
                        beat_q <= '0;
                    end
                end
                FE_READ: begin
                    if (rdy_i) begin
                        vec_q <= {rdata_i, vec_q[VEC_W-1:BUS_W]};
                        if (beat_q == BEAT_W'(NBEATS - 1)) begin
                            st_q   <= FE_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R4: a pending read keeps its request and address until ready
    assert_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !rdy_i) |=> (req_o && $stable(addr_o)));

    // R4: every fetch begins at the vector address
    assert_first_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> (addr_o == VEC_ADDR));

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
    import bootseq_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                BUS_W      = 16,
    parameter int                SETTLE_CYC = 8,
    parameter logic [ADDR_W-1:0] VEC_ADDR   = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] IRAM_START = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] HOST_START = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_sel_i,
    input  logic              strap_pin_i,
    output logic              strap_do_o,
    output logic              strap_oe_o,
    output logic              strap_pu_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rdy_i,
    input  logic [BUS_W-1:0]  mem_rdata_i,
    output logic [1:0]        boot_mode_o,
    output logic              dev_w8_o,
    output logic [ADDR_W-1:0] start_addr_o,
    output logic              done_o,
    output logic              cpu_hold_o
);
    localparam int VEC_W = ADDR_W;

    seq_state_e       state_q, state_d;
    logic             fetch_go, fetch_done;
    logic             tmr_go, tmr_exp;
    logic [VEC_W-1:0] vec;

    assign fetch_go = (state_q == ST_DECIDE) && !boot_sel_i;
    assign tmr_go   = (state_q == ST_DECIDE) && boot_sel_i;

    boot_vec_fetch #(
        .ADDR_W   (ADDR_W),
        .BUS_W    (BUS_W),
        .VEC_W    (VEC_W),
        .VEC_ADDR (VEC_ADDR)
    ) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (fetch_go),
        .rdy_i   (mem_rdy_i),
        .rdata_i (mem_rdata_i),
        .req_o   (mem_req_o),
        .addr_o  (mem_addr_o),
        .vec_o   (vec),
        .done_o  (fetch_done)
    );

    boot_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_go),
        .expire_o (tmr_exp)
    );

    // active-low chip select on the shared pin while a vector read runs
    assign strap_do_o = !mem_req_o;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DECIDE: state_d = boot_sel_i ? ST_SETTLE : ST_FETCH;
            ST_FETCH:  if (fetch_done) state_d = ST_FINISH;
            ST_SETTLE: if (tmr_exp) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DECIDE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_mode_o  <= MODE_FLASH;
            dev_w8_o     <= 1'b0;
            start_addr_o <= '0;
            done_o       <= 1'b0;
            cpu_hold_o   <= 1'b1;
            strap_oe_o   <= 1'b1;
            strap_pu_o   <= 1'b1;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_DECIDE: begin
                    if (boot_sel_i) begin
                        strap_oe_o <= 1'b0;
                        strap_pu_o <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        boot_mode_o  <= MODE_FLASH;
                        dev_w8_o     <= vec[0];
                        start_addr_o <= {vec[VEC_W-1:1], 1'b0};
                        done_o       <= 1'b1;
                        cpu_hold_o   <= 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_exp) begin
                        boot_mode_o  <= strap_pin_i ? MODE_EEPROM : MODE_HOST;
                        dev_w8_o     <= 1'b0;
                        start_addr_o <= strap_pin_i ? IRAM_START : HOST_START;
                        done_o       <= 1'b1;
                        cpu_hold_o   <= 1'b0;
                    end
                end
                ST_FINISH, ST_RUN: ;
            endcase
        end
    end

    // R8: the done pulse never lasts more than one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: once released, the decision does not move
    assert_result_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_hold_o && !done_o) |-> ($stable(start_addr_o) && $stable(boot_mode_o) && $stable(dev_w8_o)));

    // R9: hold falls only together with done
    assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_hold_o) |-> done_o);

    // R9: done never appears while the processor is still held
    assert_done_unheld_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cpu_hold_o);

    // R2: the pin is released with pull-up off throughout the settle wait
    assert_pin_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE) |-> (!strap_oe_o && !strap_pu_o));

    // R1: a finished flash boot keeps the pin as a driven chip select
    assert_flash_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_mode_o == MODE_FLASH && !cpu_hold_o) |-> (strap_oe_o && strap_pu_o));

    // R3: the mode code is always one of the three legal values
    assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        boot_mode_o != 2'b11);

endmodule

// File: tb/boot_seq_top_test.sv
module boot_seq_top_test;

    localparam int          SETTLE = 6;
    localparam logic [31:0] HOST_A = 32'h0000_0000;
    localparam logic [31:0] IRAM_A = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_sel = 1'b0;
    logic        strap_pin = 1'b1;
    logic        strap_do, strap_oe, strap_pu;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rdy = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  boot_mode;
    logic        dev_w8;
    logic [31:0] start_addr;
    logic        done;
    logic        cpu_hold;

    always #5 clk = ~clk;

    boot_seq_top #(
        .SETTLE_CYC (SETTLE),
        .HOST_START (HOST_A),
        .IRAM_START (IRAM_A)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_sel_i   (boot_sel),
        .strap_pin_i  (strap_pin),
        .strap_do_o   (strap_do),
        .strap_oe_o   (strap_oe),
        .strap_pu_o   (strap_pu),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_rdy_i    (mem_rdy),
        .mem_rdata_i  (mem_rdata),
        .boot_mode_o  (boot_mode),
        .dev_w8_o     (dev_w8),
        .start_addr_o (start_addr),
        .done_o       (done),
        .cpu_hold_o   (cpu_hold)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [1:0]  mode;
        logic [31:0] start;
        logic        w8;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    // memory model: answers each request after mem_lat idle cycles
    logic [31:0] mem_vec = '0;
    int          mem_lat = 0;
    int          mem_wait = 0;
    logic [31:0] addr_log[$];

    always @(negedge clk) begin
        if (!mem_req || mem_rdy) begin
            mem_rdy  = 1'b0;
            mem_wait = 0;
        end else if (mem_wait >= mem_lat) begin
            mem_rdy   = 1'b1;
            mem_rdata = mem_addr[1] ? mem_vec[31:16] : mem_vec[15:0];
            addr_log.push_back(mem_addr);
        end else begin
            mem_wait++;
        end
    end

    // monitor: compares each done result with the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(boot_mode == e.mode, e.tag, "boot mode", boot_mode, e.mode);
                check(start_addr == e.start, e.tag, "start address", start_addr, e.start);
                check(dev_w8 == e.w8, "R5", "width flag", dev_w8, e.w8);
            end
        end
    end

    task automatic run_boot(input logic sel, input logic strap, input logic [31:0] vec,
                            input int lat, input string tag);
        exp_t e;
        int   n;
        bit   seen, hold_bad, cs_bad, cs_seen, post_bad;
        logic [31:0] s_addr;
        logic [1:0]  s_mode;
        logic        s_w8;
        boot_sel  = sel;
        strap_pin = strap;
        mem_vec   = vec;
        mem_lat   = lat;
        addr_log.delete();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset values
        check(cpu_hold && !done && strap_pu && strap_oe && boot_mode == 2'b00 &&
              start_addr == 0 && !mem_req, "R11", "reset state",
              {cpu_hold, done, strap_pu, strap_oe, boot_mode, mem_req}, 7'b1011000);
        if (!sel) begin
            e.mode = 2'b00; e.start = {vec[31:1], 1'b0}; e.w8 = vec[0]; e.tag = tag;
        end else if (strap) begin
            e.mode = 2'b01; e.start = IRAM_A; e.w8 = 1'b0; e.tag = tag;
        end else begin
            e.mode = 2'b10; e.start = HOST_A; e.w8 = 1'b0; e.tag = tag;
        end
        exp_q.push_back(e);
        rst_n = 1'b1;
        n = 0; seen = 0; hold_bad = 0; cs_bad = 0; cs_seen = 0;
        while (!seen && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (sel && n == 1)
                check(!strap_oe && !strap_pu, "R2", "pin released, pull-up off",
                      {strap_oe, strap_pu}, 2'b00);
            if (!done && !cpu_hold) hold_bad = 1;
            if (done && cpu_hold) hold_bad = 1;
            if (mem_req && strap_do) cs_bad = 1;
            if (!mem_req && !strap_do) cs_bad = 1;
            if (mem_req) cs_seen = 1;
            if (done) seen = 1;
        end
        check(seen, "R8", "done pulse seen", seen, 1);
        check(!hold_bad, "R9", "hold tracks done", hold_bad, 0);
        check(!cs_bad, "R10", "chip select level", cs_bad, 0);
        if (sel) begin
            check(n == SETTLE + 1, "R7", "settle sampling cycle", n, SETTLE + 1);
            check(!cs_seen, "R10", "no read in strap mode", cs_seen, 0);
        end else begin
            check(cs_seen, "R10", "chip select asserted", cs_seen, 1);
            check(addr_log.size() == 2, "R4", "read count", addr_log.size(), 2);
            if (addr_log.size() == 2) begin
                check(addr_log[0] == 32'h2000_0000, "R4", "first address", addr_log[0], 32'h2000_0000);
                check(addr_log[1] == 32'h2000_0002, "R4", "second address", addr_log[1], 32'h2000_0002);
            end
            check(strap_oe && strap_pu, "R1", "pin kept as output",
                  {strap_oe, strap_pu}, 2'b11);
        end
        s_addr = start_addr; s_mode = boot_mode; s_w8 = dev_w8;
        post_bad = 0;
        repeat (10) begin
            @(negedge clk);
            if (done || cpu_hold || start_addr != s_addr || boot_mode != s_mode || dev_w8 != s_w8)
                post_bad = 1;
        end
        check(!post_bad, "R8", "results frozen after done", post_bad, 0);
        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        run_boot(1'b0, 1'b1, 32'h0000_1235, 0, "R6");
        run_boot(1'b0, 1'b0, 32'h8000_4000, 3, "R6");
        run_boot(1'b0, 1'b1, 32'hFFFF_FFFF, 1, "R1");
        run_boot(1'b1, 1'b1, 32'h0000_0000, 0, "R2");
        run_boot(1'b1, 1'b0, 32'h0000_0000, 0, "R3");
        run_boot(1'b0, 1'b0, 32'hA5C3_3C5A, 2, "R6");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule